// File: doc/BRIEF.md
# Nibble-Serial Bank Register Port

This block is the bus-side front end for a small set of bank-control registers that are reached with ordinary memory cycles rather than I/O cycles, and that see only four data lines. A write to one of four register windows counts only while an external qualifier line is held low. Each 8-bit register value therefore arrives as two qualified 4-bit writes: the low half first, the high half second. The block decodes the window from the three top address bits alone and keeps track of which half comes next. When a byte is complete, it hands that byte to the register logic behind it as a single-cycle strobe, together with the register index.

Software cannot know whether the half-tracking has drifted. It therefore opens every access with a resync: the value 2 written to the command window. This resync must work in any tracking state. It must also work whether the 02 command is sent as a lone low nibble or as a full two-nibble byte. Read cycles in a window return a 4-bit status nibble for that window. What the registers themselves do lies behind the byte strobe and is outside this block.

Top module: `nibble_reg_port`

## Requirements
- R1: After a synchronous reset, `byte_vld` and `rd_nib` are 0 and the port expects a low nibble, so the first two qualified writes to one window form a byte.
- R2: A read or write cycle has no effect while `qual_n` is high. It issues no strobe, does not change the half-tracking, and returns no status.
- R3: The window is chosen by address bits 15..13 alone. 3'b010 selects index 0, 3'b100 selects index 1, 3'b101 selects index 2 and 3'b110 selects index 3 (the command window). All other address bits are ignored. The codes 000, 001, 011 and 111 select nothing.
- R4: A qualified write of a low nibble followed by a qualified write of a high nibble to the same window raises `byte_vld` for exactly one cycle, in the cycle after the second write. `byte_idx` carries the window index and `byte_data` carries {second nibble, first nibble}.
- R5: After a byte completes, the next qualified write is taken as a low nibble again.
- R6: A qualified write of nibble 4'h2 to the command window (index 3) is a resync. It emits no byte, drops any pending low nibble, and makes the next write a low nibble. This holds whether the port was expecting a low or a high nibble.
- R7: When 02 is sent as two nibbles (2, then 0, both to the command window), the trailing 0 is held as a pending low nibble and produces no byte. A following resync discards it.
- R8: While a low nibble is pending, a qualified write to a different window discards it and is itself taken as a new low nibble, with no byte emitted.
- R9: The command values 00, 01 and 04 sent to the command window appear on `byte_idx`=3 and `byte_data` only after both of their nibbles have arrived. No strobe follows the first nibble.
- R10: A qualified read of a selected window returns `reg_status[4*idx +: 4]` on `rd_nib` in the cycle after the read. In every other cycle `rd_nib` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W (16) | Memory cycle address |
| bus_data_in | input | 4 | Data lines D3..D0 of a write |
| bus_wr | input | 1 | One-cycle memory write |
| bus_rd | input | 1 | One-cycle memory read |
| qual_n | input | 1 | Register qualifier, active low |
| reg_status | input | 16 | Status nibble of each window, index 0 in the low bits |
| rd_nib | output | 4 | Status nibble returned by a read |
| byte_vld | output | 1 | One-cycle strobe for a completed byte |
| byte_idx | output | 2 | Window index of the completed byte |
| byte_data | output | 8 | Assembled byte |

## Verification
The interesting collision is a resync arriving in the same cycle that would otherwise complete a byte. The port is holding a low nibble for the command window, and the next write is a 2 to that same window. That write could be read as a high nibble, but it must instead restart the tracking. The bench provokes this on purpose after pending low nibbles in several windows, and it also hits it at random in a long mixed stream of writes. Each time it checks that no strobe appears and that the next two writes assemble correctly. A bench model of the tracking rules predicts every strobe, index and byte.

// File: rtl/nsw_pkg.sv
package nsw_pkg;
    localparam int NIB_W     = 4;
    localparam int BYTE_W    = 2 * NIB_W;
    localparam int NUM_REGS  = 4;
    localparam int IDX_W     = $clog2(NUM_REGS);
    localparam int REGION_W  = 3;
    localparam int STATUS_W  = NUM_REGS * NIB_W;

    localparam logic [IDX_W-1:0] CMD_IDX    = IDX_W'(3);
    localparam logic [NIB_W-1:0] RESYNC_NIB = NIB_W'(2);

    typedef enum logic {EXPECT_LO, EXPECT_HI} steer_e;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } dec_t;

    typedef struct packed {
        logic [IDX_W-1:0]  idx;
        logic [BYTE_W-1:0] data;
    } byte_t;

    function automatic dec_t region_decode(input logic [REGION_W-1:0] top);
        dec_t d;
        d.hit = 1'b1;
        d.idx = '0;
        case (top)
            3'b010:  d.idx = IDX_W'(0);
            3'b100:  d.idx = IDX_W'(1);
            3'b101:  d.idx = IDX_W'(2);
            3'b110:  d.idx = IDX_W'(3);
            default: d.hit = 1'b0;
        endcase
        return d;
    endfunction
endpackage

// File: rtl/nsw_decode.sv
module nsw_decode
    import nsw_pkg::*;
(
    input  logic [REGION_W-1:0] region,
    input  logic                wr,
    input  logic                rd,
    input  logic                strobe_n,
    output dec_t                wr_dec,
    output dec_t                rd_dec
);
    dec_t base;

    always_comb begin
        base       = region_decode(region);
        wr_dec     = base;
        rd_dec     = base;
        wr_dec.hit = base.hit && wr && !strobe_n;
        rd_dec.hit = base.hit && rd && !strobe_n;
    end
endmodule

// File: rtl/nsw_steer.sv
module nsw_steer
    import nsw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  dec_t             wr_dec,
    input  logic [NIB_W-1:0] nib,
    output logic             byte_vld,
    output byte_t            byte_out
);
    steer_e           state;
    logic [IDX_W-1:0] pend_idx;
    logic [NIB_W-1:0] pend_lo;
    logic             is_resync;
    logic             is_fresh;

    assign is_resync = (wr_dec.idx == CMD_IDX) && (nib == RESYNC_NIB);
    assign is_fresh  = (state == EXPECT_LO) || (wr_dec.idx != pend_idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= EXPECT_LO;
            pend_idx <= '0;
            pend_lo  <= '0;
            byte_vld <= 1'b0;
            byte_out <= '0;
        end else begin
            byte_vld <= 1'b0;
            if (wr_dec.hit) begin
                if (is_resync) begin
                    state <= EXPECT_LO;
                end else if (is_fresh) begin
                    pend_idx <= wr_dec.idx;
                    pend_lo  <= nib;
                    state    <= EXPECT_HI;
                end else begin
                    byte_vld      <= 1'b1;
                    byte_out.idx  <= wr_dec.idx;
                    byte_out.data <= {nib, pend_lo};
                    state         <= EXPECT_LO;
                end
            end
        end
    end

    // A byte strobe is always the result of a qualified write one cycle earlier (R4)
    assert_strobe_from_write_R4: assert property (@(posedge clk) disable iff (rst)
        byte_vld |-> $past(wr_dec.hit));

    // The strobe never lasts two cycles (R4)
    assert_single_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        byte_vld |=> !byte_vld);

    // A resync write never produces a byte (R6)
    assert_resync_silent_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_dec.hit && is_resync) |=> !byte_vld);

    // After a completed byte the next nibble is a low one (R5)
    assert_back_to_low_R5: assert property (@(posedge clk) disable iff (rst)
        byte_vld |-> state == EXPECT_LO);

    // Without a qualified write the tracking state holds (R2)
    assert_idle_holds_R2: assert property (@(posedge clk) disable iff (rst)
        !wr_dec.hit |=> $stable(state));
endmodule

// File: rtl/nsw_readback.sv
module nsw_readback
    import nsw_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  dec_t                rd_dec,
    input  logic [STATUS_W-1:0] status,
    output logic [NIB_W-1:0]    rd_nib
);
    logic [NIB_W-1:0] slot [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
        assign slot[g] = status[g*NIB_W +: NIB_W];
    end

    always_ff @(posedge clk) begin
        if (rst)
            rd_nib <= '0;
        else
            rd_nib <= rd_dec.hit ? slot[rd_dec.idx] : '0;
    end

    // No qualified read means an idle, zero readback next cycle (R10)
    assert_idle_zero_R10: assert property (@(posedge clk) disable iff (rst)
        !rd_dec.hit |=> rd_nib == '0);
endmodule

// File: rtl/nibble_reg_port.sv
module nibble_reg_port
    import nsw_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [NIB_W-1:0]    bus_data_in,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic                qual_n,
    input  logic [STATUS_W-1:0] reg_status,
    output logic [NIB_W-1:0]    rd_nib,
    output logic                byte_vld,
    output logic [IDX_W-1:0]    byte_idx,
    output logic [BYTE_W-1:0]   byte_data
);
    localparam int LOW_W = ADDR_W - REGION_W;

    dec_t  wr_dec;
    dec_t  rd_dec;
    byte_t byte_out;
    logic  addr_low_unused;

    assign addr_low_unused = ^bus_addr[LOW_W-1:0];

    nsw_decode u_decode (
        .region   (bus_addr[ADDR_W-1 -: REGION_W]),
        .wr       (bus_wr),
        .rd       (bus_rd),
        .strobe_n (qual_n),
        .wr_dec   (wr_dec),
        .rd_dec   (rd_dec)
    );

    nsw_steer u_steer (
        .clk      (clk),
        .rst      (rst),
        .wr_dec   (wr_dec),
        .nib      (bus_data_in),
        .byte_vld (byte_vld),
        .byte_out (byte_out)
    );

    nsw_readback u_readback (
        .clk    (clk),
        .rst    (rst),
        .rd_dec (rd_dec),
        .status (reg_status),
        .rd_nib (rd_nib)
    );

    assign byte_idx  = byte_out.idx;
    assign byte_data = byte_out.data;

    // A write with the qualifier high never yields a byte (R2)
    assert_unqualified_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && qual_n && !bus_rd) |=> !byte_vld);
endmodule

// File: tb/test_nibble_reg_port.sv
module test_nibble_reg_port;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] bus_addr = '0;
    logic [3:0]  bus_data_in = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic        qual_n = 1'b1;
    logic [15:0] reg_status = '0;
    logic [3:0]  rd_nib;
    logic        byte_vld;
    logic [1:0]  byte_idx;
    logic [7:0]  byte_data;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // bench model of the tracking rules
    bit       m_hi = 1'b0;
    bit [1:0] m_idx = '0;
    bit [3:0] m_lo = '0;

    always #5 clk = ~clk;

    nibble_reg_port i_nibble_reg_port (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_data_in(bus_data_in),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .qual_n(qual_n), .reg_status(reg_status),
        .rd_nib(rd_nib), .byte_vld(byte_vld), .byte_idx(byte_idx), .byte_data(byte_data)
    );

    function automatic bit code_hit(input bit [2:0] c);
        return (c == 3'b010) || (c == 3'b100) || (c == 3'b101) || (c == 3'b110);
    endfunction

    function automatic bit [1:0] code_idx(input bit [2:0] c);
        case (c)
            3'b100:  return 2'd1;
            3'b101:  return 2'd2;
            3'b110:  return 2'd3;
            default: return 2'd0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_nib(input bit [2:0] code, input bit [3:0] nib, input bit qn, input string req);
        bit       e_vld = 1'b0;
        bit [1:0] e_idx = '0;
        bit [7:0] e_dat = '0;
        @(negedge clk);
        bus_addr    = {code, 13'($urandom)};
        bus_data_in = nib;
        bus_wr      = 1'b1;
        qual_n      = qn;
        if (!qn && code_hit(code)) begin
            if (code_idx(code) == 2'd3 && nib == 4'h2) begin
                m_hi = 1'b0;
            end else if (!m_hi || code_idx(code) != m_idx) begin
                m_hi = 1'b1; m_idx = code_idx(code); m_lo = nib;
            end else begin
                e_vld = 1'b1; e_idx = m_idx; e_dat = {nib, m_lo}; m_hi = 1'b0;
            end
        end
        @(negedge clk);
        bus_wr = 1'b0;
        qual_n = 1'b1;
        chk(byte_vld == e_vld, {req, " strobe"}, byte_vld, e_vld);
        if (e_vld) begin
            chk(byte_idx == e_idx, {req, " index"}, byte_idx, e_idx);
            chk(byte_data == e_dat, {req, " data"}, byte_data, e_dat);
        end
    endtask

    task automatic rd_chk(input bit [2:0] code, input bit qn, input string req);
        bit [3:0] e;
        @(negedge clk);
        reg_status = 16'($urandom);
        bus_addr   = {code, 13'($urandom)};
        bus_rd     = 1'b1;
        qual_n     = qn;
        e = (!qn && code_hit(code)) ? reg_status[4*code_idx(code) +: 4] : 4'h0;
        @(negedge clk);
        bus_rd = 1'b0;
        qual_n = 1'b1;
        chk(rd_nib == e, req, rd_nib, e);
        @(negedge clk);
        chk(rd_nib == 4'h0, {req, " idle"}, rd_nib, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(byte_vld == 1'b0, "R1 strobe after reset", byte_vld, 0);
        chk(rd_nib == 4'h0, "R1 readback after reset", rd_nib, 0);
        wr_nib(3'b010, 4'h5, 1'b0, "R1 first low");
        wr_nib(3'b010, 4'hA, 1'b0, "R1 R4 first byte");
        // R2 unqualified writes ignored
        wr_nib(3'b100, 4'h3, 1'b1, "R2 unqualified low");
        wr_nib(3'b100, 4'h4, 1'b0, "R2 low");
        wr_nib(3'b100, 4'hF, 1'b1, "R2 unqualified mid-byte");
        wr_nib(3'b100, 4'h6, 1'b0, "R2 high");
        // R3 decode
        wr_nib(3'b000, 4'h1, 1'b0, "R3 unmapped 000");
        wr_nib(3'b111, 4'h1, 1'b0, "R3 unmapped 111");
        wr_nib(3'b101, 4'hC, 1'b0, "R3 window A low");
        wr_nib(3'b011, 4'h9, 1'b0, "R3 unmapped 011 mid-byte");
        wr_nib(3'b101, 4'h7, 1'b0, "R3 window A byte");
        // R5 back-to-back bytes
        wr_nib(3'b100, 4'h1, 1'b0, "R5 low 1");
        wr_nib(3'b100, 4'h2, 1'b0, "R5 byte 1");
        wr_nib(3'b100, 4'h3, 1'b0, "R5 low 2");
        wr_nib(3'b100, 4'h4, 1'b0, "R5 byte 2");
        // R6 resync while a high nibble is due, in two windows
        wr_nib(3'b100, 4'h7, 1'b0, "R6 pending low");
        wr_nib(3'b110, 4'h2, 1'b0, "R6 resync mid-byte");
        wr_nib(3'b100, 4'h1, 1'b0, "R6 low after resync");
        wr_nib(3'b100, 4'h3, 1'b0, "R6 byte after resync");
        wr_nib(3'b110, 4'h0, 1'b0, "R6 pending command low");
        wr_nib(3'b110, 4'h2, 1'b0, "R6 resync collides with high");
        wr_nib(3'b110, 4'h2, 1'b0, "R6 resync while expecting low");
        wr_nib(3'b010, 4'hE, 1'b0, "R6 low");
        wr_nib(3'b010, 4'hD, 1'b0, "R6 byte");
        // R7 / R8 two-nibble 02
        wr_nib(3'b110, 4'h2, 1'b0, "R7 02 low half");
        wr_nib(3'b110, 4'h0, 1'b0, "R7 02 high half held");
        wr_nib(3'b010, 4'h9, 1'b0, "R8 other window replaces pending");
        wr_nib(3'b010, 4'h8, 1'b0, "R8 byte");
        wr_nib(3'b110, 4'h2, 1'b0, "R7 02 low half again");
        wr_nib(3'b110, 4'h0, 1'b0, "R7 trailing zero");
        wr_nib(3'b110, 4'h2, 1'b0, "R7 resync discards zero");
        wr_nib(3'b101, 4'h4, 1'b0, "R7 low");
        wr_nib(3'b101, 4'h5, 1'b0, "R7 byte");
        // R9 commands
        wr_nib(3'b110, 4'h2, 1'b0, "R9 resync");
        wr_nib(3'b110, 4'h0, 1'b0, "R9 cmd00 first half");
        wr_nib(3'b110, 4'h0, 1'b0, "R9 cmd00");
        wr_nib(3'b110, 4'h1, 1'b0, "R9 cmd01 first half");
        wr_nib(3'b110, 4'h0, 1'b0, "R9 cmd01");
        wr_nib(3'b110, 4'h4, 1'b0, "R9 cmd04 first half");
        wr_nib(3'b110, 4'h0, 1'b0, "R9 cmd04");
        // R10 readback
        rd_chk(3'b010, 1'b0, "R10 read window 0");
        rd_chk(3'b100, 1'b0, "R10 read window 1");
        rd_chk(3'b101, 1'b0, "R10 read window 2");
        rd_chk(3'b110, 1'b0, "R10 read window 3");
        rd_chk(3'b001, 1'b0, "R10 R3 read unmapped");
        rd_chk(3'b101, 1'b1, "R10 R2 read unqualified");
        // random mix, resync-heavy on the command window
        for (int i = 0; i < 600; i++) begin
            bit [2:0] c = 3'($urandom);
            bit [3:0] n = 4'($urandom);
            bit       q = ($urandom % 8) == 0;
            if (($urandom % 4) == 0) c = 3'b110;
            if (($urandom % 6) == 0) n = 4'h2;
            if (($urandom % 10) == 0) rd_chk(c, q, "R10 random read");
            else wr_nib(c, n, q, "R4 R6 R8 random write");
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule